// File: doc/BRIEF.md
# Daisy-Chain Match and Full Flag Cascade

This block forms the chained match and full flags of one content-addressable memory device that sits in a daisy chain of such devices. It takes the device's raw local conditions (some location hit, more than one location hit, every location used), registers them, and combines them with the upstream chain inputs to produce the downstream chain outputs. It also drives the internal match qualifier that chain arbitration uses to decide whether this device may respond.

Two configuration fields, one for each flag, can switch a flag off. Switching off the match flag takes the device out of the chain. Its internal match qualifier stays inactive and the upstream match passes straight through. Switching off the full flag makes the device act as permanently full. The upstream full passes straight through, and the device raises an inhibit line that tells the instruction decoder to drop next-free-address instructions and page-register writes. The local match, multiple-match and status outputs always report the true registered state, whatever the two fields hold.

Top module: `flagc_cascade`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, stat_match, stat_multi and stat_full are 0, all_match_n and multi_match_n are 1, and match_int_n is 1.
- R2: hit_raw, multi_raw and full_raw are captured on the rising clock edge and appear on the status outputs after exactly REG_STAGES edges (one by default).
- R3: With the match field enabled, match_out_n is 0 exactly when match_in_n is 0 or the registered hit is 1. Otherwise it is 1.
- R4: With the match field enabled, match_int_n is the inverse of the registered hit.
- R5: A match field equal to DIS_CODE (default 2'b01) disables the match flag: match_int_n stays 1 and match_out_n equals match_in_n.
- R6: all_match_n, multi_match_n, stat_match and stat_multi follow the registered conditions whatever the match field holds.
- R7: With the full field enabled, full_out_n is 0 only when full_in_n is 0 and the registered full is 1. acts_full equals the registered full.
- R8: A full field equal to DIS_CODE disables the full flag: full_out_n equals full_in_n and acts_full is 1.
- R9: gate_inh is 1 exactly when the full field equals DIS_CODE. It stays 0 while the field is enabled, even when the device is truly full.
- R10: stat_full follows the registered full condition whatever the full field holds.
- R11: Field values other than DIS_CODE (2'b00, 2'b10, 2'b11 by default) all behave as enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_raw | input | 1 | Local array reports at least one matching location |
| multi_raw | input | 1 | Local array reports more than one matching location |
| full_raw | input | 1 | Local array has no free location |
| match_in_n | input | 1 | Upstream chained match, active low |
| full_in_n | input | 1 | Upstream chained full, active low |
| match_en_fld | input | CFG_W | Match flag enable field; DIS_CODE disables |
| full_en_fld | input | CFG_W | Full flag enable field; DIS_CODE disables |
| match_out_n | output | 1 | Downstream chained match, active low |
| match_int_n | output | 1 | Internal match qualifier for chain arbitration, active low |
| all_match_n | output | 1 | True local match, active low |
| multi_match_n | output | 1 | True local multiple match, active low |
| full_out_n | output | 1 | Downstream chained full, active low |
| acts_full | output | 1 | Device is to be treated as full |
| gate_inh | output | 1 | Inhibit for next-free-address instructions and page-register writes |
| stat_match | output | 1 | Status: true registered hit |
| stat_multi | output | 1 | Status: true registered multiple hit |
| stat_full | output | 1 | Status: true registered full |

## Verification
The bench aims at the disabled settings. In each one the upstream input must reach the output untouched while the local condition is set to the value that would disagree with it. A design that only masked the output would drive a constant there and fail to pass the chain through. The bench drives a truly full device with the full field enabled, where a design that tied the inhibit to the full state would wrongly block instructions. It also walks all four field codes, so that a decoder testing a single bit would be caught treating a reserved code as disabled. Status and local match outputs are read under every field setting, which exposes any design that lets an enable field leak into the true state.

// File: rtl/flagc_pkg.sv
package flagc_pkg;

   // Raw local conditions reported by the array, active high.
   typedef struct packed {
      logic hit;
      logic multi;
      logic full;
   } cond_t;

   localparam cond_t COND_IDLE = '{hit: 1'b0, multi: 1'b0, full: 1'b0};

endpackage

// File: rtl/flagc_cond_pipe.sv
module flagc_cond_pipe
   import flagc_pkg::*;
#(
   parameter int unsigned STAGES = 1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  cond_t cond_d,
   output cond_t cond_q
);

   localparam int unsigned LAST = STAGES;

   cond_t stage [LAST+1];

   assign stage[0] = cond_d;

   for (genvar gi = 1; gi <= LAST; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage[gi] <= COND_IDLE;
         else        stage[gi] <= stage[gi-1];
      end
   end

   assign cond_q = stage[LAST];

endmodule

// File: rtl/flagc_match_link.sv
module flagc_match_link #(
   parameter int unsigned CFG_W    = 2,
   parameter int unsigned DIS_CODE = 1
) (
   input  logic             hit_q,
   input  logic             match_in_n,
   input  logic [CFG_W-1:0] en_fld,
   output logic             match_out_n,
   output logic             match_int_n
);

   localparam logic [CFG_W-1:0] DIS_VAL = DIS_CODE[CFG_W-1:0];

   logic off;
   assign off = (en_fld == DIS_VAL);

   always_comb begin
      if (off) begin
         // Out of the chain: never claims a match, forwards upstream.
         match_int_n = 1'b1;
         match_out_n = match_in_n;
      end else begin
         match_int_n = ~hit_q;
         match_out_n = match_in_n & ~hit_q;
      end
   end

endmodule

// File: rtl/flagc_full_link.sv
module flagc_full_link #(
   parameter int unsigned CFG_W    = 2,
   parameter int unsigned DIS_CODE = 1
) (
   input  logic             full_q,
   input  logic             full_in_n,
   input  logic [CFG_W-1:0] en_fld,
   output logic             full_out_n,
   output logic             acts_full,
   output logic             gate_inh
);

   localparam logic [CFG_W-1:0] DIS_VAL = DIS_CODE[CFG_W-1:0];

   logic off;
   assign off = (en_fld == DIS_VAL);

   always_comb begin
      if (off) begin
         // Treated as permanently full; upstream full is forwarded.
         full_out_n = full_in_n;
         acts_full  = 1'b1;
         gate_inh   = 1'b1;
      end else begin
         full_out_n = ~(~full_in_n & full_q);
         acts_full  = full_q;
         gate_inh   = 1'b0;
      end
   end

endmodule

// File: rtl/flagc_cascade.sv
module flagc_cascade
   import flagc_pkg::*;
#(
   parameter int unsigned CFG_W      = 2,
   parameter int unsigned DIS_CODE   = 1,
   parameter int unsigned REG_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_raw,
   input  logic             multi_raw,
   input  logic             full_raw,
   input  logic             match_in_n,
   input  logic             full_in_n,
   input  logic [CFG_W-1:0] match_en_fld,
   input  logic [CFG_W-1:0] full_en_fld,
   output logic             match_out_n,
   output logic             match_int_n,
   output logic             all_match_n,
   output logic             multi_match_n,
   output logic             full_out_n,
   output logic             acts_full,
   output logic             gate_inh,
   output logic             stat_match,
   output logic             stat_multi,
   output logic             stat_full
);

   initial begin : prm_chk
      assert (CFG_W >= 1 && CFG_W <= 8)
         else $error("flagc_cascade: CFG_W out of range");
      assert (DIS_CODE < (1 << CFG_W))
         else $error("flagc_cascade: DIS_CODE does not fit CFG_W");
      assert (REG_STAGES >= 1 && REG_STAGES <= 4)
         else $error("flagc_cascade: REG_STAGES out of range");
   end

   cond_t cond_d;
   cond_t cond_q;

   assign cond_d = '{hit: hit_raw, multi: multi_raw, full: full_raw};

   flagc_cond_pipe #(
      .STAGES (REG_STAGES)
   ) pipe_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond_d (cond_d),
      .cond_q (cond_q)
   );

   flagc_match_link #(
      .CFG_W    (CFG_W),
      .DIS_CODE (DIS_CODE)
   ) mlink_i (
      .hit_q       (cond_q.hit),
      .match_in_n  (match_in_n),
      .en_fld      (match_en_fld),
      .match_out_n (match_out_n),
      .match_int_n (match_int_n)
   );

   flagc_full_link #(
      .CFG_W    (CFG_W),
      .DIS_CODE (DIS_CODE)
   ) flink_i (
      .full_q     (cond_q.full),
      .full_in_n  (full_in_n),
      .en_fld     (full_en_fld),
      .full_out_n (full_out_n),
      .acts_full  (acts_full),
      .gate_inh   (gate_inh)
   );

   // True state, independent of either enable field.
   assign all_match_n   = ~cond_q.hit;
   assign multi_match_n = ~cond_q.multi;
   assign stat_match    = cond_q.hit;
   assign stat_multi    = cond_q.multi;
   assign stat_full     = cond_q.full;

endmodule

// File: rtl/flagc_cascade_chk.sv
module flagc_cascade_chk #(
   parameter int unsigned CFG_W      = 2,
   parameter int unsigned DIS_CODE   = 1,
   parameter int unsigned REG_STAGES = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hit_raw,
   input logic             multi_raw,
   input logic             full_raw,
   input logic             match_in_n,
   input logic             full_in_n,
   input logic [CFG_W-1:0] match_en_fld,
   input logic [CFG_W-1:0] full_en_fld,
   input logic             match_out_n,
   input logic             match_int_n,
   input logic             all_match_n,
   input logic             multi_match_n,
   input logic             full_out_n,
   input logic             acts_full,
   input logic             gate_inh,
   input logic             stat_match,
   input logic             stat_multi,
   input logic             stat_full
);

   localparam logic [CFG_W-1:0] DIS_VAL = DIS_CODE[CFG_W-1:0];

   // R5: a disabled match flag never claims a match and forwards upstream
   assert_match_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (match_en_fld == DIS_VAL) |-> (match_int_n && match_out_n == match_in_n));

   // R3: an upstream match always reaches the output when enabled
   assert_match_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (match_en_fld != DIS_VAL && !match_in_n) |-> !match_out_n);

   // R6: local match outputs agree with status whatever the field holds
   assert_true_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (all_match_n == !stat_match) && (multi_match_n == !stat_multi));

   // R8: a disabled full flag forwards upstream and acts full
   assert_full_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (full_en_fld == DIS_VAL) |-> (acts_full && full_out_n == full_in_n));

   // R7: with upstream not full, an enabled device never reports chain full
   assert_full_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full_en_fld != DIS_VAL && full_in_n) |-> full_out_n);

   // R9: inhibit only when the full flag is disabled
   assert_gate_inh_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gate_inh == (full_en_fld == DIS_VAL));

   // R2: one-stage capture of the raw conditions
   if (REG_STAGES == 1) begin : g_lat
      assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (stat_match == $past(hit_raw) &&
                           stat_multi == $past(multi_raw) &&
                           stat_full  == $past(full_raw)));
   end

endmodule

bind flagc_cascade flagc_cascade_chk #(
   .CFG_W      (CFG_W),
   .DIS_CODE   (DIS_CODE),
   .REG_STAGES (REG_STAGES)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .hit_raw       (hit_raw),
   .multi_raw     (multi_raw),
   .full_raw      (full_raw),
   .match_in_n    (match_in_n),
   .full_in_n     (full_in_n),
   .match_en_fld  (match_en_fld),
   .full_en_fld   (full_en_fld),
   .match_out_n   (match_out_n),
   .match_int_n   (match_int_n),
   .all_match_n   (all_match_n),
   .multi_match_n (multi_match_n),
   .full_out_n    (full_out_n),
   .acts_full     (acts_full),
   .gate_inh      (gate_inh),
   .stat_match    (stat_match),
   .stat_multi    (stat_multi),
   .stat_full     (stat_full)
);

// File: tb/flagc_cascade_tb_top.sv
module flagc_cascade_tb_top;

   localparam int CFG_W = 2;
   localparam logic [1:0] EN_A = 2'b00;
   localparam logic [1:0] OFF  = 2'b01;
   localparam logic [1:0] EN_B = 2'b10;
   localparam logic [1:0] EN_C = 2'b11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hit_raw = 1'b0, multi_raw = 1'b0, full_raw = 1'b0;
   logic match_in_n = 1'b1, full_in_n = 1'b1;
   logic [CFG_W-1:0] match_en_fld = EN_A, full_en_fld = EN_A;
   logic match_out_n, match_int_n, all_match_n, multi_match_n;
   logic full_out_n, acts_full, gate_inh, stat_match, stat_multi, stat_full;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   flagc_cascade dut_i (
      .clk(clk), .rst_n(rst_n), .hit_raw(hit_raw), .multi_raw(multi_raw),
      .full_raw(full_raw), .match_in_n(match_in_n), .full_in_n(full_in_n),
      .match_en_fld(match_en_fld), .full_en_fld(full_en_fld),
      .match_out_n(match_out_n), .match_int_n(match_int_n),
      .all_match_n(all_match_n), .multi_match_n(multi_match_n),
      .full_out_n(full_out_n), .acts_full(acts_full), .gate_inh(gate_inh),
      .stat_match(stat_match), .stat_multi(stat_multi), .stat_full(stat_full)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // Drive local conditions at a falling edge, let one rising edge pass.
   task automatic load(input logic h, input logic m, input logic f);
      @(negedge clk);
      hit_raw = h; multi_raw = m; full_raw = f;
      @(negedge clk);
   endtask

   task automatic t_reset();
      #1;
      check("R1 stat_match in reset", stat_match, 1'b0);
      check("R1 stat_full in reset", stat_full, 1'b0);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 stat_multi", stat_multi, 1'b0);
      check("R1 all_match_n", all_match_n, 1'b1);
      check("R1 multi_match_n", multi_match_n, 1'b1);
      check("R1 match_int_n", match_int_n, 1'b1);
   endtask

   task automatic t_capture();
      @(negedge clk);
      hit_raw = 1'b1; multi_raw = 1'b1; full_raw = 1'b1;
      #1;
      check("R2 no change before edge", stat_match, 1'b0);
      @(negedge clk);
      check("R2 hit after one edge", stat_match, 1'b1);
      check("R2 multi after one edge", stat_multi, 1'b1);
      check("R2 full after one edge", stat_full, 1'b1);
      load(1'b0, 1'b0, 1'b0);
      check("R2 hit cleared", stat_match, 1'b0);
   endtask

   task automatic t_match_on(input logic [1:0] code, input string req);
      match_en_fld = code;
      for (int h = 0; h < 2; h++) begin
         load(h[0], 1'b0, 1'b0);
         for (int mi = 0; mi < 2; mi++) begin
            match_in_n = mi[0];
            #1;
            check({req, " R3 match_out_n"}, match_out_n, !((mi == 0) || (h == 1)));
            check({req, " R4 match_int_n"}, match_int_n, !(h == 1));
         end
      end
      match_in_n = 1'b1;
   endtask

   task automatic t_match_off();
      match_en_fld = OFF;
      load(1'b1, 1'b1, 1'b0);
      match_in_n = 1'b1; #1;
      check("R5 match_out_n follows high input", match_out_n, 1'b1);
      check("R5 match_int_n held", match_int_n, 1'b1);
      match_in_n = 1'b0; #1;
      check("R5 match_out_n follows low input", match_out_n, 1'b0);
      check("R6 all_match_n true", all_match_n, 1'b0);
      check("R6 multi_match_n true", multi_match_n, 1'b0);
      check("R6 stat_match true", stat_match, 1'b1);
      check("R6 stat_multi true", stat_multi, 1'b1);
      load(1'b0, 1'b0, 1'b0);
      check("R5 match_out_n no local hit", match_out_n, 1'b0);
      check("R6 all_match_n cleared", all_match_n, 1'b1);
      match_in_n = 1'b1;
      match_en_fld = EN_A;
   endtask

   task automatic t_full_on(input logic [1:0] code, input string req);
      full_en_fld = code;
      for (int f = 0; f < 2; f++) begin
         load(1'b0, 1'b0, f[0]);
         for (int fi = 0; fi < 2; fi++) begin
            full_in_n = fi[0];
            #1;
            check({req, " R7 full_out_n"}, full_out_n, !((fi == 0) && (f == 1)));
            check({req, " R7 acts_full"}, acts_full, f[0]);
            check({req, " R9 gate_inh low"}, gate_inh, 1'b0);
            check({req, " R10 stat_full"}, stat_full, f[0]);
         end
      end
      full_in_n = 1'b1;
   endtask

   task automatic t_full_off();
      full_en_fld = OFF;
      load(1'b0, 1'b0, 1'b0);
      full_in_n = 1'b0; #1;
      check("R8 full_out_n follows low input", full_out_n, 1'b0);
      check("R8 acts_full forced", acts_full, 1'b1);
      check("R9 gate_inh raised", gate_inh, 1'b1);
      check("R10 stat_full true empty", stat_full, 1'b0);
      load(1'b0, 1'b0, 1'b1);
      full_in_n = 1'b1; #1;
      check("R8 full_out_n follows high input", full_out_n, 1'b1);
      check("R10 stat_full true full", stat_full, 1'b1);
      full_en_fld = EN_A; #1;
      check("R9 gate_inh drops on enable", gate_inh, 1'b0);
      load(1'b0, 1'b0, 1'b0);
   endtask

   initial begin : main
      t_reset();
      t_capture();
      t_match_on(EN_A, "code00");
      t_match_off();
      t_full_on(EN_A, "code00");
      t_full_off();
      // R11: reserved codes behave as enabled
      t_match_on(EN_B, "R11 code10");
      t_match_on(EN_C, "R11 code11");
      t_full_on(EN_B, "R11 code10");
      t_full_on(EN_C, "R11 code11");
      done = 1'b1;
   end

   initial begin : watchdog
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule